// File: doc/BRIEF.md
# Multiframe SYSREF Generator and Local Multiframe Counter

This block runs in the link clock domain of a serial converter receiver. It produces a periodic one-cycle SYSREF pulse whose period equals the multiframe length. That pulse is meant for the local receiver and for the external converter. The block also keeps a local multiframe counter. The counter is restarted whenever a SYSREF rising edge is captured, so every device that shares the pulse counts multiframes in step.

The multiframe length in link clocks comes from the frame size (octets per frame) and the frames per multiframe. The datapath carries four octets per clock, so the length is octets × frames / 4. A programmable offset moves the multiframe boundary later by a number of link clocks. This is used to trim deterministic latency.

Capture has two modes. In continuous mode every rising edge realigns the counter. In single-detection mode only the first rising edge after arming is used. That edge clears a status flag, and later edges are ignored until software re-arms the block. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `mframe_sync_gen`

## Requirements
- R1: `cfg_ok` is 1, and the multiframe length is `frame_octets*frames_per_mf/4` link clocks, exactly when that product is a multiple of 4, is at least 8, and its quarter fits in `CNT_W` bits.
- R2: While `cfg_ok` is 1, `sysref_out` is a one-cycle pulse that repeats every multiframe-length cycles.
- R3: While `cfg_ok` is 0, `sysref_out` and `lmfc_bnd` stay 0, `lmfc_cnt` is held at 0, and a SYSREF edge has no effect.
- R4: An accepted rising edge on `sysref_in`, sampled at a clock edge, sets `lmfc_cnt` after that edge to (length − effective offset) mod length. After that the counter increments by one per clock and wraps to 0 after length − 1.
- R5: `lmfc_bnd` is 1 exactly in the cycles where `cfg_ok` is 1 and `lmfc_cnt` is 0. As a result, the first boundary after a capture comes effective-offset cycles after the capture edge.
- R6: The effective offset is `lmfc_offset` when that value is below the length, and length − 1 otherwise.
- R7: Only a 0-to-1 transition of `sysref_in` counts as an edge. Holding it at 1 realigns the counter once, and the counter then keeps counting.
- R8: With `mode_cont` = 1, every rising edge is accepted, and `sd_armed` does not change except through `sd_arm`.
- R9: With `mode_cont` = 0, a rising edge is accepted only while `sd_armed` is 1. The accepted edge clears `sd_armed` after that clock edge, and later edges leave `lmfc_cnt` counting undisturbed.
- R10: A 1 on `sd_arm` sets `sd_armed` at the next clock edge. This has priority, so `sd_armed` stays 1 even when an edge is accepted in the same cycle.
- R11: While `rst_link` is high, `sysref_out` is 0, `lmfc_cnt` is 0 and `sd_armed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_link | input | 1 | Link clock |
| rst_link | input | 1 | Synchronous reset, active high |
| frame_octets | input | F_W | Octets per frame |
| frames_per_mf | input | K_W | Frames per multiframe |
| lmfc_offset | input | CNT_W | Boundary delay in link clocks |
| mode_cont | input | 1 | 1 = realign on every edge, 0 = single detection |
| sd_arm | input | 1 | Re-arm single detection |
| sysref_in | input | 1 | SYSREF as received, link clock domain |
| sysref_out | output | 1 | Generated SYSREF pulse |
| lmfc_bnd | output | 1 | Multiframe boundary strobe |
| lmfc_cnt | output | CNT_W | Local multiframe counter |
| cfg_ok | output | 1 | Length configuration valid |
| sd_armed | output | 1 | Single detection still pending (0 = consumed) |

## Verification
`cfg_ok` follows the configuration inputs in the same cycle. The counter value and `sd_armed` respond one clock edge after the edge that samples the `sysref_in` rise or the `sd_arm` pulse. The generated pulse recurs every length cycles. The bench changes inputs at the falling edge and reads outputs at the next falling edge, so each check lands on the first cycle in which the result is due. It then steps through the counter cycle by cycle, computing (load + j) mod length and the boundary arithmetically.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  // capture behaviour for incoming SYSREF edges
  typedef enum logic {
    CAP_SINGLE = 1'b0,
    CAP_CONT   = 1'b1
  } cap_mode_e;

  // datapath width in octets per link clock
  localparam int unsigned OCTETS_PER_BEAT = 4;
  localparam int unsigned BEAT_SHIFT      = $clog2(OCTETS_PER_BEAT);
  // shortest multiframe accepted, in link clocks
  localparam int unsigned MIN_LEN         = 2;
endpackage

// File: rtl/mfs_len_calc.sv
module mfs_len_calc
  import mfs_pkg::*;
#(
  parameter int F_W   = 4,
  parameter int K_W   = 6,
  parameter int CNT_W = 8
) (
  input  logic [F_W-1:0]   octets,
  input  logic [K_W-1:0]   frames,
  output logic [CNT_W-1:0] len,
  output logic             ok
);
  localparam int PROD_W = F_W + K_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quarter;
  logic              fits;

  assign prod    = PROD_W'(octets) * PROD_W'(frames);
  assign quarter = prod >> BEAT_SHIFT;

  generate
    if (CNT_W >= PROD_W) begin : g_wide
      assign fits = 1'b1;
      assign len  = CNT_W'(quarter);
    end else begin : g_narrow
      assign fits = ~|quarter[PROD_W-1:CNT_W];
      assign len  = quarter[CNT_W-1:0];
    end
  endgenerate

  assign ok = (prod[BEAT_SHIFT-1:0] == '0) &&
              (quarter >= PROD_W'(MIN_LEN)) && fits;
endmodule

// File: rtl/mfs_period_gen.sv
module mfs_period_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ok,
  input  logic [CNT_W-1:0] len,
  output logic             pulse
);
  logic [CNT_W-1:0] tick_q;
  logic             last;

  assign last = (tick_q >= len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !ok) begin
      tick_q <= '0;
      pulse  <= 1'b0;
    end else begin
      tick_q <= last ? '0 : tick_q + CNT_W'(1);
      pulse  <= last;
    end
  end
endmodule

// File: rtl/mfs_edge_capture.sv
module mfs_edge_capture
  import mfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ok,
  input  logic sref,
  input  logic mode_cont,
  input  logic arm,
  output logic take,
  output logic armed
);
  cap_mode_e mode;
  logic      prev_q;
  logic      rise;

  assign mode = cap_mode_e'(mode_cont);
  assign rise = sref & ~prev_q;
  assign take = ok & rise & ((mode == CAP_CONT) | armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      armed  <= 1'b1;
    end else begin
      prev_q <= sref;
      if (arm)
        armed <= 1'b1;
      else if (take && mode == CAP_SINGLE)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mfs_lmfc_counter.sv
module mfs_lmfc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ok,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] offset,
  input  logic             realign,
  output logic [CNT_W-1:0] cnt,
  output logic             bnd
);
  logic [CNT_W-1:0] off_eff;
  logic [CNT_W-1:0] preload;
  logic             wrap;

  // offsets beyond the multiframe saturate to its last cycle
  assign off_eff = (offset >= len) ? len - CNT_W'(1) : offset;
  assign preload = (off_eff == '0) ? '0 : len - off_eff;
  assign wrap    = (cnt >= len - CNT_W'(1));
  assign bnd     = ok && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !ok)
      cnt <= '0;
    else if (realign)
      cnt <= preload;
    else
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/mframe_sync_gen.sv
module mframe_sync_gen #(
  parameter int F_W   = 4,
  parameter int K_W   = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk_link,
  input  logic             rst_link,
  input  logic [F_W-1:0]   frame_octets,
  input  logic [K_W-1:0]   frames_per_mf,
  input  logic [CNT_W-1:0] lmfc_offset,
  input  logic             mode_cont,
  input  logic             sd_arm,
  input  logic             sysref_in,
  output logic             sysref_out,
  output logic             lmfc_bnd,
  output logic [CNT_W-1:0] lmfc_cnt,
  output logic             cfg_ok,
  output logic             sd_armed
);
  logic [CNT_W-1:0] mf_len;
  logic             take;

  mfs_len_calc #(.F_W(F_W), .K_W(K_W), .CNT_W(CNT_W)) u_len (
    .octets (frame_octets),
    .frames (frames_per_mf),
    .len    (mf_len),
    .ok     (cfg_ok)
  );

  mfs_period_gen #(.CNT_W(CNT_W)) u_gen (
    .clk   (clk_link),
    .rst   (rst_link),
    .ok    (cfg_ok),
    .len   (mf_len),
    .pulse (sysref_out)
  );

  mfs_edge_capture u_cap (
    .clk       (clk_link),
    .rst       (rst_link),
    .ok        (cfg_ok),
    .sref      (sysref_in),
    .mode_cont (mode_cont),
    .arm       (sd_arm),
    .take      (take),
    .armed     (sd_armed)
  );

  mfs_lmfc_counter #(.CNT_W(CNT_W)) u_lmfc (
    .clk     (clk_link),
    .rst     (rst_link),
    .ok      (cfg_ok),
    .len     (mf_len),
    .offset  (lmfc_offset),
    .realign (take),
    .cnt     (lmfc_cnt),
    .bnd     (lmfc_bnd)
  );
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
  parameter int F_W   = 4,
  parameter int K_W   = 6,
  parameter int CNT_W = 8
) (
  input logic             clk_link,
  input logic             rst_link,
  input logic [F_W-1:0]   frame_octets,
  input logic [K_W-1:0]   frames_per_mf,
  input logic [CNT_W-1:0] lmfc_offset,
  input logic             mode_cont,
  input logic             sd_arm,
  input logic             sysref_in,
  input logic             sysref_out,
  input logic             lmfc_bnd,
  input logic [CNT_W-1:0] lmfc_cnt,
  input logic             cfg_ok,
  input logic             sd_armed
);
  p_pulse_single_r2: assert property (@(posedge clk_link) disable iff (rst_link)
    sysref_out |=> !sysref_out);

  p_quiet_invalid_r3: assert property (@(posedge clk_link) disable iff (rst_link)
    (!cfg_ok && $past(!cfg_ok)) |-> (!sysref_out && !lmfc_bnd && lmfc_cnt == '0));

  p_zero_align_r4: assert property (@(posedge clk_link) disable iff (rst_link)
    (cfg_ok && mode_cont && sysref_in && !$past(sysref_in) && lmfc_offset == '0)
    |=> lmfc_cnt == '0);

  p_count_step_r4: assert property (@(posedge clk_link) disable iff (rst_link)
    (lmfc_cnt != '0 && $past(cfg_ok) && $past(!sysref_in) &&
     $stable(frame_octets) && $stable(frames_per_mf))
    |-> lmfc_cnt == $past(lmfc_cnt) + CNT_W'(1));

  p_cont_keeps_r8: assert property (@(posedge clk_link) disable iff (rst_link)
    (mode_cont && !sd_arm) |=> sd_armed == $past(sd_armed));

  p_consume_r9: assert property (@(posedge clk_link) disable iff (rst_link)
    (!mode_cont && sd_armed && !sd_arm && cfg_ok && sysref_in && !$past(sysref_in))
    |=> !sd_armed);

  p_stay_consumed_r9: assert property (@(posedge clk_link) disable iff (rst_link)
    (!sd_armed && !sd_arm) |=> !sd_armed);

  p_arm_r10: assert property (@(posedge clk_link) disable iff (rst_link)
    sd_arm |=> sd_armed);
endmodule

bind mframe_sync_gen mfs_checker #(.F_W(F_W), .K_W(K_W), .CNT_W(CNT_W)) u_chk (
  .clk_link      (clk_link),
  .rst_link      (rst_link),
  .frame_octets  (frame_octets),
  .frames_per_mf (frames_per_mf),
  .lmfc_offset   (lmfc_offset),
  .mode_cont     (mode_cont),
  .sd_arm        (sd_arm),
  .sysref_in     (sysref_in),
  .sysref_out    (sysref_out),
  .lmfc_bnd      (lmfc_bnd),
  .lmfc_cnt      (lmfc_cnt),
  .cfg_ok        (cfg_ok),
  .sd_armed      (sd_armed)
);

// File: tb/mframe_sync_gen_test.sv
`timescale 1ns/1ps
module mframe_sync_gen_test;
  localparam int F_W   = 4;
  localparam int K_W   = 6;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic [F_W-1:0]   f_in;
  logic [K_W-1:0]   k_in;
  logic [CNT_W-1:0] off_in;
  logic             cont, arm, sref;
  logic             sysref_out, lmfc_bnd, cfg_ok, sd_armed;
  logic [CNT_W-1:0] lmfc_cnt;

  int vec  = 0;
  int miss = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mframe_sync_gen #(.F_W(F_W), .K_W(K_W), .CNT_W(CNT_W)) uut (
    .clk_link(clk), .rst_link(rst), .frame_octets(f_in), .frames_per_mf(k_in),
    .lmfc_offset(off_in), .mode_cont(cont), .sd_arm(arm), .sysref_in(sref),
    .sysref_out(sysref_out), .lmfc_bnd(lmfc_bnd), .lmfc_cnt(lmfc_cnt),
    .cfg_ok(cfg_ok), .sd_armed(sd_armed)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int f, input int k, input int off);
    f_in   = F_W'(f);
    k_in   = K_W'(k);
    off_in = CNT_W'(off);
    step();
    step();
  endtask

  // one-cycle SYSREF, then trace the counter for span cycles
  task automatic capture_run(input int len, input int off, input int span);
    int offe, load, e;
    offe = (off >= len) ? len - 1 : off;            // R6
    load = (offe == 0) ? 0 : len - offe;
    sref = 1'b1;
    step();
    sref = 1'b0;
    for (int j = 0; j <= span; j++) begin
      if (j > 0) step();
      e = (load + j) % len;
      chk("R4 count after capture", int'(lmfc_cnt), e);
      chk("R5 boundary strobe", int'(lmfc_bnd), int'(e == 0));
    end
  endtask

  task automatic period_run(input int len);
    int w, n;
    w = 0;
    while (!sysref_out && w < 400) begin step(); w++; end
    chk("R2 pulse present", int'(sysref_out), 1);
    n = 0;
    do begin step(); n++; end while (!sysref_out && n < 400);
    chk("R2 pulse period", n, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    int fs[4];
    int ks[4];
    int bf[4];
    int bk[4];
    int len;
    fs = '{1, 2, 4, 8};
    ks = '{8, 16, 20, 32};
    bf = '{1, 2, 0, 3};
    bk = '{4, 3, 16, 5};

    rst = 1'b1; cont = 1'b0; arm = 1'b0; sref = 1'b0;
    f_in = 4'd2; k_in = 6'd16; off_in = '0;
    @(negedge clk);
    repeat (3) step();
    // R11 reset state
    chk("R11 sysref_out in reset", int'(sysref_out), 0);
    chk("R11 count in reset", int'(lmfc_cnt), 0);
    chk("R11 armed in reset", int'(sd_armed), 1);
    rst = 1'b0;
    repeat (3) step();

    // single detection, length 8
    chk("R1 cfg ok 2x16", int'(cfg_ok), 1);
    sref = 1'b1; step(); sref = 1'b0;
    chk("R9 first edge aligns", int'(lmfc_cnt), 0);
    chk("R9 armed consumed", int'(sd_armed), 0);
    repeat (3) step();
    chk("R4 counting", int'(lmfc_cnt), 3);
    sref = 1'b1; step(); sref = 1'b0;
    chk("R9 second edge ignored", int'(lmfc_cnt), 4);
    chk("R9 stays consumed", int'(sd_armed), 0);
    arm = 1'b1; step(); arm = 1'b0;
    chk("R10 rearm sets flag", int'(sd_armed), 1);
    chk("R10 rearm leaves count", int'(lmfc_cnt), 5);
    step(); step();
    sref = 1'b1; step(); sref = 1'b0;
    chk("R9 rearmed edge aligns", int'(lmfc_cnt), 0);
    chk("R9 rearmed edge consumes", int'(sd_armed), 0);
    arm = 1'b1; step(); arm = 1'b0;
    step();
    arm = 1'b1; sref = 1'b1; step(); arm = 1'b0; sref = 1'b0;
    chk("R10 arm with edge aligns", int'(lmfc_cnt), 0);
    chk("R10 arm wins over consume", int'(sd_armed), 1);
    step();
    sref = 1'b1; step(); sref = 1'b0;
    chk("R9 consume again", int'(sd_armed), 0);

    // continuous mode, level held high
    cont = 1'b1;
    repeat (3) step();
    sref = 1'b1; step();
    chk("R8 continuous aligns", int'(lmfc_cnt), 0);
    chk("R8 flag untouched", int'(sd_armed), 0);
    for (int j = 1; j <= 20; j++) begin
      step();
      chk("R7 held level no realign", int'(lmfc_cnt), j % 8);
    end
    sref = 1'b0; step();
    chk("R7 count after release", int'(lmfc_cnt), 21 % 8);
    sref = 1'b1; step(); sref = 1'b0;
    chk("R8 every edge aligns", int'(lmfc_cnt), 0);
    chk("R8 flag still untouched", int'(sd_armed), 0);

    // invalid configurations
    for (int c = 0; c < 4; c++) begin
      set_cfg(bf[c], bk[c], 0);
      chk("R3 cfg rejected", int'(cfg_ok), 0);
      for (int j = 0; j < 40; j++) begin
        sref = (j == 10);
        step();
        chk("R3 no pulse", int'(sysref_out), 0);
        chk("R3 no boundary", int'(lmfc_bnd), 0);
        chk("R3 count held", int'(lmfc_cnt), 0);
      end
      sref = 1'b0;
    end

    // sweep of valid configurations and offsets, continuous mode
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        len = fs[a] * ks[b] / 4;
        set_cfg(fs[a], ks[b], 0);
        chk("R1 cfg accepted", int'(cfg_ok), 1);
        period_run(len);
        capture_run(len, 0, len + 2);
        off_in = CNT_W'(1); step();
        capture_run(len, 1, len + 2);
        off_in = CNT_W'(2); step();
        capture_run(len, 2, len + 2);
        off_in = CNT_W'(len + 5); step();
        capture_run(len, len + 5, len + 2);      // R6 saturation
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule